// File: doc/BRIEF.md
# Layered Display Pixel Compositor

This block merges two pixel streams that arrive in lockstep: the colour index produced by a host graphics source and the 8-bit pixel read from a local framestore. The framestore holds either a combined radar-and-map layer or live camera video. For each pixel, the block picks one palette index and a layer tag. The tag tells the palette stage which lookup table to use.

The host index is split into three classes by two programmable thresholds: overlay, underlay and transparent. A host value of zero is always transparent. Overlay always wins over everything else. A transparent host pixel lets the local pixel through. Underlay is shown only over radar whose intensity has faded below a programmable level. This lets map symbols appear as the radar trail fades.

The local pixel can be read in two ways. In shared mode, a video pixel carries a 7-bit grey level. In split mode, a video pixel carries a 6-bit intensity and a selector bit, which picks a monochrome palette for daylight camera video or a pseudo-colour palette for thermal video. The result is registered, so it appears two clocks after its inputs, and the line and frame markers are delayed by the same amount.

Top module: `pixel_compositor`

## Requirements
- R1: The host index is classed in this order. A value of 0 is transparent. Otherwise, a value at or above `cfg_ovl_thr` is overlay. Otherwise, a value at or above `cfg_unl_thr` is underlay. Anything else is transparent.
- R2: An overlay pixel outputs the host index with tag 1 (overlay), whatever the local pixel holds.
- R3: A transparent host pixel outputs the local pixel unchanged, with the tag of its local layer.
- R4: A local pixel with bit 7 = 0 is radar/map content. Its intensity is bits 6:0. It outputs with tag 3 (radar).
- R5: In shared mode (`cfg_split` = 0), a local pixel with bit 7 = 1 is video. It outputs with tag 4 (video, 128 levels).
- R6: In split mode (`cfg_split` = 1), a local pixel with bit 7 = 1 is video with a 6-bit intensity in bits 5:0. Bit 6 = 1 selects tag 6 (pseudo-colour) and bit 6 = 0 selects tag 5 (monochrome).
- R7: An underlay pixel over radar content outputs the host index with tag 2 (underlay) when the radar intensity is strictly below `cfg_fade_thr`. Otherwise it outputs the radar pixel with tag 3.
- R8: An underlay pixel over video content outputs the video pixel and its video tag.
- R9: A pixel presented with `in_valid` = 0 produces `out_valid` = 0, index 0 and tag 0 (blank).
- R10: Index, tag, `out_valid`, `out_sol` and `out_sof` follow their inputs exactly two clock edges later. All configuration inputs apply to the pixel presented in the same cycle.
- R11: While `rst_n` is low, every output is held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_split | input | 1 | 0 = shared 7-bit video, 1 = 6-bit video plus palette selector |
| cfg_ovl_thr | input | HOST_W | Lowest host index treated as overlay |
| cfg_unl_thr | input | HOST_W | Lowest host index treated as underlay |
| cfg_fade_thr | input | LOC_W-1 | Radar intensity below which underlay shows |
| in_valid | input | 1 | Pixel qualifier |
| in_sol | input | 1 | Start-of-line marker |
| in_sof | input | 1 | Start-of-frame marker |
| host_pix | input | HOST_W | Host graphics colour index |
| local_pix | input | LOC_W | Local framestore pixel |
| out_valid | output | 1 | Delayed pixel qualifier |
| out_sol | output | 1 | Delayed start-of-line marker |
| out_sof | output | 1 | Delayed start-of-frame marker |
| out_index | output | PIX_W | Selected palette index |
| out_tag | output | 3 | Layer tag: 0 blank, 1 overlay, 2 underlay, 3 radar, 4 video, 5 mono, 6 pseudo |

## Verification
Every result and every marker is due exactly two edges after its pixel is presented. The bench drives each pixel on a falling edge and compares the outputs for the pixel driven two falling edges earlier. This keeps a stream of table vectors in flight, each with its own configuration. A directed test sends a single pixel after idle cycles and confirms that nothing appears one edge later and that the result appears at the second edge. The reset test checks that the outputs clear at the first edge with `rst_n` low, even while pixels are in flight.

// File: rtl/pixcomp_pkg.sv
// Shared types for the pixel compositor: the layer tag sent to the palette
// stage and the class assigned to a host pixel. Assumes a 3-bit tag field.
package pixcomp_pkg;

    typedef enum logic [2:0] {
        TAG_BLANK      = 3'd0,
        TAG_OVERLAY    = 3'd1,
        TAG_UNDERLAY   = 3'd2,
        TAG_RADAR      = 3'd3,
        TAG_VIDEO      = 3'd4,
        TAG_VID_MONO   = 3'd5,
        TAG_VID_PSEUDO = 3'd6
    } layer_tag_e;

    typedef enum logic [1:0] {
        HC_CLEAR = 2'd0,
        HC_UNDER = 2'd1,
        HC_OVER  = 2'd2
    } host_class_e;

endpackage

// File: rtl/host_classifier.sv
// Classes a host colour index as overlay, underlay or transparent using two
// thresholds. Zero is always transparent, and overlay is tested before
// underlay. Purely combinational.
module host_classifier
    import pixcomp_pkg::*;
#(
    parameter int HOST_W = 8
) (
    input  logic [HOST_W-1:0] host_pix,
    input  logic [HOST_W-1:0] ovl_thr,
    input  logic [HOST_W-1:0] unl_thr,
    output host_class_e       hclass
);

    // Black first, then overlay, then underlay (R1).
    always_comb begin
        if (host_pix == '0)
            hclass = HC_CLEAR;
        else if (host_pix >= ovl_thr)
            hclass = HC_OVER;
        else if (host_pix >= unl_thr)
            hclass = HC_UNDER;
        else
            hclass = HC_CLEAR;
    end

endmodule

// File: rtl/local_decoder.sv
// Interprets a local framestore pixel. The MSB separates radar/map content
// from video. For video, the split mode reads the next bit as a palette
// selector. Also reports the radar intensity. Purely combinational.
module local_decoder
    import pixcomp_pkg::*;
#(
    parameter  int LOC_W = 8,
    localparam int LVL_W = LOC_W - 1
) (
    input  logic [LOC_W-1:0] local_pix,
    input  logic             split,
    output layer_tag_e       kind,
    output logic [LVL_W-1:0] level
);

    // Radar intensity always occupies the bits below the MSB.
    assign level = local_pix[LVL_W-1:0];

    // Select the layer tag from the MSB, the mode and the selector bit.
    always_comb begin
        if (!local_pix[LOC_W-1])
            kind = TAG_RADAR;
        else if (!split)
            kind = TAG_VIDEO;
        else if (local_pix[LOC_W-2])
            kind = TAG_VID_PSEUDO;
        else
            kind = TAG_VID_MONO;
    end

endmodule

// File: rtl/layer_select.sv
// Final priority decision for one pixel: blank, overlay, faded-radar
// underlay, or the local pixel. Assumes the inputs are already registered
// by the caller. Purely combinational.
module layer_select
    import pixcomp_pkg::*;
#(
    parameter  int HOST_W = 8,
    parameter  int LOC_W  = 8,
    localparam int PIX_W  = (HOST_W > LOC_W) ? HOST_W : LOC_W
) (
    input  logic              valid,
    input  host_class_e       hclass,
    input  logic [HOST_W-1:0] host_pix,
    input  logic [LOC_W-1:0]  local_pix,
    input  layer_tag_e        kind,
    input  logic              faded,
    output logic [PIX_W-1:0]  index,
    output layer_tag_e        tag
);

    // Apply the priority order: blank, overlay, underlay over faded radar, local.
    always_comb begin
        if (!valid) begin
            index = '0;
            tag   = TAG_BLANK;
        end else if (hclass == HC_OVER) begin
            index = PIX_W'(host_pix);
            tag   = TAG_OVERLAY;
        end else if (hclass == HC_UNDER && kind == TAG_RADAR && faded) begin
            index = PIX_W'(host_pix);
            tag   = TAG_UNDERLAY;
        end else begin
            index = PIX_W'(local_pix);
            tag   = kind;
        end
    end

endmodule

// File: rtl/marker_delay.sv
// Fixed-depth shift register for the timing markers, so that they stay aligned
// with the pixel pipeline. Requires DEPTH >= 1.
module marker_delay #(
    parameter int W     = 2,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] pipe [DEPTH];

    generate
        for (genvar s = 0; s < DEPTH; s++) begin : g_stage
            // Shift one stage per clock and clear on reset.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    pipe[s] <= '0;
                else if (s == 0)
                    pipe[s] <= din;
                else
                    pipe[s] <= pipe[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign dout = pipe[DEPTH-1];

endmodule

// File: rtl/pixel_compositor.sv
// Top level of the layered pixel compositor. Stage 1 registers the
// classified host pixel and the decoded local pixel, including the
// fade comparison. Stage 2 registers the selected index and tag. The
// configuration is sampled with the pixel. The host and local streams are
// assumed to be pixel-aligned.
module pixel_compositor
    import pixcomp_pkg::*;
#(
    parameter  int HOST_W = 8,
    parameter  int LOC_W  = 8,
    localparam int PIX_W  = (HOST_W > LOC_W) ? HOST_W : LOC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_split,
    input  logic [HOST_W-1:0] cfg_ovl_thr,
    input  logic [HOST_W-1:0] cfg_unl_thr,
    input  logic [LOC_W-2:0]  cfg_fade_thr,
    input  logic              in_valid,
    input  logic              in_sol,
    input  logic              in_sof,
    input  logic [HOST_W-1:0] host_pix,
    input  logic [LOC_W-1:0]  local_pix,
    output logic              out_valid,
    output logic              out_sol,
    output logic              out_sof,
    output logic [PIX_W-1:0]  out_index,
    output logic [2:0]        out_tag
);

    localparam int LVL_W    = LOC_W - 1;
    localparam int LATENCY  = 2;

    host_class_e       hclass_c;
    layer_tag_e        kind_c;
    logic [LVL_W-1:0]  level_c;

    host_class_e       s1_hclass;
    layer_tag_e        s1_kind;
    logic              s1_valid;
    logic              s1_faded;
    logic [HOST_W-1:0] s1_host;
    logic [LOC_W-1:0]  s1_local;

    logic [PIX_W-1:0]  sel_index;
    layer_tag_e        sel_tag;

    host_classifier #(.HOST_W(HOST_W)) u_hcls (
        .host_pix (host_pix),
        .ovl_thr  (cfg_ovl_thr),
        .unl_thr  (cfg_unl_thr),
        .hclass   (hclass_c)
    );

    local_decoder #(.LOC_W(LOC_W)) u_ldec (
        .local_pix (local_pix),
        .split     (cfg_split),
        .kind      (kind_c),
        .level     (level_c)
    );

    // Stage 1: hold the classification, the decoded layer and the fade comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid  <= 1'b0;
            s1_hclass <= HC_CLEAR;
            s1_kind   <= TAG_RADAR;
            s1_faded  <= 1'b0;
            s1_host   <= '0;
            s1_local  <= '0;
        end else begin
            s1_valid  <= in_valid;
            s1_hclass <= hclass_c;
            s1_kind   <= kind_c;
            s1_faded  <= (level_c < cfg_fade_thr);
            s1_host   <= host_pix;
            s1_local  <= local_pix;
        end
    end

    layer_select #(.HOST_W(HOST_W), .LOC_W(LOC_W)) u_sel (
        .valid     (s1_valid),
        .hclass    (s1_hclass),
        .host_pix  (s1_host),
        .local_pix (s1_local),
        .kind      (s1_kind),
        .faded     (s1_faded),
        .index     (sel_index),
        .tag       (sel_tag)
    );

    // Stage 2: register the chosen palette index, tag and qualifier.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_index <= '0;
            out_tag   <= TAG_BLANK;
        end else begin
            out_valid <= s1_valid;
            out_index <= sel_index;
            out_tag   <= sel_tag;
        end
    end

    marker_delay #(.W(2), .DEPTH(LATENCY)) u_mark (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({in_sof, in_sol}),
        .dout  ({out_sof, out_sol})
    );

endmodule

// File: rtl/pixcomp_checker.sv
// Temporal properties of the pixel compositor, bound to the top. A small
// counter tracks the edges since reset, so that two-cycle lookbacks never
// reach into the reset period.
module pixcomp_checker
    import pixcomp_pkg::*;
#(
    parameter  int HOST_W = 8,
    parameter  int LOC_W  = 8,
    localparam int PIX_W  = (HOST_W > LOC_W) ? HOST_W : LOC_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [HOST_W-1:0] cfg_ovl_thr,
    input logic              in_valid,
    input logic              in_sol,
    input logic              in_sof,
    input logic [HOST_W-1:0] host_pix,
    input logic              out_valid,
    input logic              out_sol,
    input logic              out_sof,
    input logic [PIX_W-1:0]  out_index,
    input logic [2:0]        out_tag
);

    logic [1:0] since_rst;

    // Count edges out of reset, saturating at the pipeline depth.
    always_ff @(posedge clk) begin
        if (!rst_n)
            since_rst <= '0;
        else if (since_rst != 2'd2)
            since_rst <= since_rst + 2'd1;
    end

    wire warm = (since_rst == 2'd2);

    a_r10_latency: assert property (@(posedge clk) disable iff (!rst_n)
        warm |-> (out_valid == $past(in_valid, 2)) && (out_sol == $past(in_sol, 2))
                 && (out_sof == $past(in_sof, 2)));

    a_r2_overlay_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(in_valid, 2) && ($past(host_pix, 2) != '0)
         && ($past(host_pix, 2) >= $past(cfg_ovl_thr, 2)))
        |-> (out_tag == TAG_OVERLAY) && (out_index == PIX_W'($past(host_pix, 2))));

    a_r3_black_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(in_valid, 2) && ($past(host_pix, 2) == '0))
        |-> (out_tag != TAG_OVERLAY) && (out_tag != TAG_UNDERLAY));

    a_r9_blank: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_index == '0) && (out_tag == TAG_BLANK));

    a_r6_pseudo_code: assert property (@(posedge clk) disable iff (!rst_n)
        (out_tag == TAG_VID_PSEUDO) |-> (out_index[LOC_W-1:LOC_W-2] == 2'b11));

endmodule

bind pixel_compositor pixcomp_checker #(.HOST_W(HOST_W), .LOC_W(LOC_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_ovl_thr (cfg_ovl_thr),
    .in_valid    (in_valid),
    .in_sol      (in_sol),
    .in_sof      (in_sof),
    .host_pix    (host_pix),
    .out_valid   (out_valid),
    .out_sol     (out_sol),
    .out_sof     (out_sof),
    .out_index   (out_index),
    .out_tag     (out_tag)
);

// File: tb/tb_pixel_compositor.sv
`timescale 1ns/1ps
module tb_pixel_compositor;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_split = 1'b0;
    logic [7:0] cfg_ovl_thr = 8'hC0;
    logic [7:0] cfg_unl_thr = 8'h40;
    logic [6:0] cfg_fade_thr = 7'h20;
    logic       in_valid = 1'b0, in_sol = 1'b0, in_sof = 1'b0;
    logic [7:0] host_pix = 8'h00, local_pix = 8'h00;
    logic       out_valid, out_sol, out_sof;
    logic [7:0] out_index;
    logic [2:0] out_tag;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    pixel_compositor dut (
        .clk(clk), .rst_n(rst_n), .cfg_split(cfg_split),
        .cfg_ovl_thr(cfg_ovl_thr), .cfg_unl_thr(cfg_unl_thr), .cfg_fade_thr(cfg_fade_thr),
        .in_valid(in_valid), .in_sol(in_sol), .in_sof(in_sof),
        .host_pix(host_pix), .local_pix(local_pix),
        .out_valid(out_valid), .out_sol(out_sol), .out_sof(out_sof),
        .out_index(out_index), .out_tag(out_tag)
    );

    typedef struct packed {
        logic       v;
        logic       split;
        logic [7:0] ovl;
        logic [7:0] unl;
        logic [6:0] fade;
        logic [7:0] host;
        logic [7:0] loc;
        logic [7:0] exp_pix;
        logic [2:0] exp_tag;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 8'hC0, 8'h40, 7'h20, 8'hC5, 8'h85, 8'hC5, 3'd1}, // R2 overlay over video
        '{1'b1, 1'b0, 8'hC0, 8'h40, 7'h20, 8'hFF, 8'h10, 8'hFF, 3'd1}, // R2 overlay over radar
        '{1'b1, 1'b0, 8'hC0, 8'h40, 7'h20, 8'h00, 8'h12, 8'h12, 3'd3}, // R3 R4 black shows radar
        '{1'b1, 1'b0, 8'hC0, 8'h40, 7'h20, 8'h00, 8'h9A, 8'h9A, 3'd4}, // R5 shared video
        '{1'b1, 1'b1, 8'hC0, 8'h40, 7'h20, 8'h00, 8'hC7, 8'hC7, 3'd6}, // R6 pseudo-colour
        '{1'b1, 1'b1, 8'hC0, 8'h40, 7'h20, 8'h00, 8'h85, 8'h85, 3'd5}, // R6 monochrome
        '{1'b1, 1'b0, 8'hC0, 8'h40, 7'h20, 8'h50, 8'h10, 8'h50, 3'd2}, // R7 faded radar
        '{1'b1, 1'b0, 8'hC0, 8'h40, 7'h20, 8'h50, 8'h20, 8'h20, 3'd3}, // R7 at threshold
        '{1'b1, 1'b0, 8'hC0, 8'h40, 7'h20, 8'h50, 8'h30, 8'h30, 3'd3}, // R7 bright radar
        '{1'b1, 1'b0, 8'hC0, 8'h40, 7'h20, 8'h50, 8'h9A, 8'h9A, 3'd4}, // R8 underlay over video
        '{1'b1, 1'b0, 8'hC0, 8'h40, 7'h20, 8'h3F, 8'h05, 8'h05, 3'd3}, // R1 below underlay thr
        '{1'b1, 1'b0, 8'hC0, 8'h40, 7'h20, 8'h40, 8'h00, 8'h40, 3'd2}, // R1 at underlay thr
        '{1'b1, 1'b0, 8'hC0, 8'h40, 7'h20, 8'hBF, 8'h7F, 8'h7F, 3'd3}, // R1 underlay, bright radar
        '{1'b1, 1'b0, 8'hC0, 8'h40, 7'h20, 8'hC0, 8'h00, 8'hC0, 3'd1}, // R1 at overlay thr
        '{1'b0, 1'b0, 8'hC0, 8'h40, 7'h20, 8'hC5, 8'h85, 8'h00, 3'd0}, // R9 invalid pixel
        '{1'b1, 1'b0, 8'h00, 8'h00, 7'h20, 8'h00, 8'h33, 8'h33, 3'd3}, // R1 zero stays clear
        '{1'b1, 1'b0, 8'h00, 8'h00, 7'h20, 8'h01, 8'h33, 8'h01, 3'd1}, // R1 zero overlay thr
        '{1'b1, 1'b1, 8'hC0, 8'h40, 7'h00, 8'h50, 8'h00, 8'h00, 3'd3}  // R7 zero fade thr
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input int i);
        if (i < NV) begin
            in_valid     = VECS[i].v;
            cfg_split    = VECS[i].split;
            cfg_ovl_thr  = VECS[i].ovl;
            cfg_unl_thr  = VECS[i].unl;
            cfg_fade_thr = VECS[i].fade;
            host_pix     = VECS[i].host;
            local_pix    = VECS[i].loc;
            in_sol       = (i % 4 == 0);
            in_sof       = (i == 0);
        end else begin
            in_valid = 1'b0; in_sol = 1'b0; in_sof = 1'b0;
            host_pix = 8'h00; local_pix = 8'h00;
        end
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: outputs cleared under reset
        check("R11 reset", {out_valid, out_sol, out_sof, out_index, out_tag}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: vector i driven at falling edge i, checked two falling edges later (R10)
        for (int i = 0; i < NV + 2; i++) begin
            if (i >= 2) begin
                check("R1-table index", out_index, VECS[i-2].exp_pix);
                check("R1-table tag", out_tag, VECS[i-2].exp_tag);
                check("R10 valid", out_valid, VECS[i-2].v);
                check("R10 sol", out_sol, ((i-2) % 4 == 0));
                check("R10 sof", out_sof, (i-2 == 0));
            end
            drive(i);
            @(negedge clk);
        end

        // R10: a lone pixel after idle appears at the second edge, not the first
        cfg_split = 1'b0; cfg_ovl_thr = 8'hC0; cfg_unl_thr = 8'h40; cfg_fade_thr = 7'h20;
        repeat (3) @(negedge clk);
        in_valid = 1'b1; host_pix = 8'hE1; local_pix = 8'h11; in_sol = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; host_pix = 8'h00; in_sol = 1'b0;
        check("R10 not after one edge", out_valid, 1'b0);
        @(negedge clk);
        check("R10 after two edges valid", {out_valid, out_sol}, 2'b11);
        check("R10 after two edges index", out_index, 8'hE1);
        @(negedge clk);
        check("R9 blank after lone pixel", {out_valid, out_index, out_tag}, 12'd0);

        // R11: reset in the middle of a valid stream clears outputs at the next edge
        in_valid = 1'b1; host_pix = 8'hC8; in_sof = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R11 reset mid-stream", {out_valid, out_sol, out_sof, out_index, out_tag}, 32'd0);
        rst_n = 1'b1;
        in_valid = 1'b0; in_sof = 1'b0;
        @(negedge clk);
        check("R11 no stale pixel after reset", out_valid, 1'b0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule